// File: doc/BRIEF.md
# BCD Calendar Time-of-Day Counter

This block keeps wall-clock time and date as seven packed-BCD fields: seconds, minutes, hours (24-hour), day of the week, day of the month, month and a two-digit year. Each field holds its tens digit in bits [7:4] and its units digit in bits [3:0]. The count moves forward by exactly one second for each single-cycle pulse on `tick`. Carries ripple through every field. Month lengths and leap years are handled from the two-digit year, which is read as a calendar year between 1950 and 2049.

Software sets the clock through a load port: a field select, a data byte and a write strobe. While `hold` is high, ticks are dropped so that a multi-field update cannot tear, and writes are still accepted. Every field output comes straight from a register.

Top module: `rtc_calendar_core`

## Requirements
- R1: After a synchronous reset the fields read year 0x00, month 0x01, day 0x01, weekday 0x07, hour 0x00, minute 0x00, second 0x00.
- R2: Each accepted tick advances seconds by one in BCD. The units digit rolls from 9 to 0 and increments the tens digit. Seconds and minutes roll from 0x59 to 0x00, and that roll advances the next field.
- R3: Hours roll from 0x23 to 0x00. That roll advances both the day of month and the weekday.
- R4: The weekday runs from 0x01 (Sunday) to 0x07 and rolls from 0x07 to 0x01.
- R5: The day of month rolls to 0x01 and advances the month after day 0x31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 0x30 in months 04, 06, 09 and 11.
- R6: In month 0x02 the last day is 0x29 when the year yy, read as the calendar year ((yy+50) mod 100)+1950, is divisible by 4, so that year 00 (2000) is a leap year. Otherwise the last day is 0x28.
- R7: The month rolls from 0x12 to 0x01 and advances the year. The year rolls from 0x99 to 0x00.
- R8: While `hold` is 1, `tick` is ignored and no field changes unless a write occurs.
- R9: When `wr_en` is 1, the field chosen by `wr_sel` takes `wr_data` on the next clock edge. The select codes are 0 second, 1 minute, 2 hour, 3 weekday, 4 day, 5 month and 6 year. Code 7 writes nothing. Writes are accepted while `hold` is 1.
- R10: When `wr_en` and `tick` are both 1 in the same cycle, the write takes effect and that tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance strobe, one cycle wide |
| hold | input | 1 | Freeze counting while high |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for a write |
| wr_data | input | 8 | Packed-BCD value to write |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, 24-hour |
| wday_o | output | 8 | Weekday, 1 means Sunday |
| mday_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD, 1-based |
| year_o | output | 8 | Two-digit year, BCD |

## Verification
A field write and a second tick can land in the same cycle. In that case the write must win and the tick must vanish. The bench provokes this by presetting the seconds, then pulsing `tick` together with a minute write. It then checks that the minute holds the written value and that the seconds have not moved. It also pairs a write with `hold` to show that the write still lands while ticks are frozen.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 7;
  localparam int SEL_W      = 3;

  localparam logic [SEL_W-1:0] F_SEC  = 3'd0;
  localparam logic [SEL_W-1:0] F_MIN  = 3'd1;
  localparam logic [SEL_W-1:0] F_HOUR = 3'd2;
  localparam logic [SEL_W-1:0] F_WDAY = 3'd3;
  localparam logic [SEL_W-1:0] F_MDAY = 3'd4;
  localparam logic [SEL_W-1:0] F_MON  = 3'd5;
  localparam logic [SEL_W-1:0] F_YEAR = 3'd6;

  function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [FIELD_W-1:0] RST_VAL = 8'h00,
  parameter logic [FIELD_W-1:0] MIN_VAL = 8'h00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  input  logic               ld,
  input  logic [FIELD_W-1:0] ld_data,
  input  logic [FIELD_W-1:0] lim,
  output logic [FIELD_W-1:0] q,
  output logic               at_lim
);
  // BCD ordering is numeric for valid digits, so a plain compare also
  // catches an out-of-range value written by software
  assign at_lim = (q >= lim);

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (ld)  q <= ld_data;
    else if (inc) q <= at_lim ? MIN_VAL : bcd_inc(q);
  end

  // R2: an accepted increment below the limit always moves the field
  a_r2_step_moves: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && !at_lim) |=> (q != $past(q)));
  // R2: a field at its limit restarts at its minimum
  a_r2_wrap_min: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && at_lim) |=> (q == MIN_VAL));
endmodule

// File: rtl/rtc_month_days.sv
module rtc_month_days
  import rtc_pkg::*;
(
  input  logic [FIELD_W-1:0] mon,
  input  logic [FIELD_W-1:0] year,
  output logic [FIELD_W-1:0] last_day
);
  logic [6:0] year_bin;
  logic       leap;

  // 1900 and 2000 are both multiples of 4, so divisibility of the mapped
  // calendar year reduces to divisibility of the two-digit value
  assign year_bin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
  assign leap     = (year_bin[1:0] == 2'b00);

  always_comb begin
    unique case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               hold,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [FIELD_W-1:0] wr_data,
  output logic [FIELD_W-1:0] sec_o,
  output logic [FIELD_W-1:0] min_o,
  output logic [FIELD_W-1:0] hour_o,
  output logic [FIELD_W-1:0] wday_o,
  output logic [FIELD_W-1:0] mday_o,
  output logic [FIELD_W-1:0] mon_o,
  output logic [FIELD_W-1:0] year_o
);
  localparam logic [FIELD_W-1:0] RST_TAB [NUM_FIELDS] =
    '{8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h00};
  localparam logic [FIELD_W-1:0] MIN_TAB [NUM_FIELDS] =
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};

  logic [FIELD_W-1:0] fq   [NUM_FIELDS];
  logic [FIELD_W-1:0] flim [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] finc, fld, fat;
  logic [FIELD_W-1:0] feb_last;
  logic step;

  // a write anywhere swallows the tick of the same cycle
  assign step = tick && !hold && !wr_en;

  always_comb begin
    finc[F_SEC]  = step;
    finc[F_MIN]  = finc[F_SEC]  && fat[F_SEC];
    finc[F_HOUR] = finc[F_MIN]  && fat[F_MIN];
    finc[F_WDAY] = finc[F_HOUR] && fat[F_HOUR];
    finc[F_MDAY] = finc[F_HOUR] && fat[F_HOUR];
    finc[F_MON]  = finc[F_MDAY] && fat[F_MDAY];
    finc[F_YEAR] = finc[F_MON]  && fat[F_MON];
  end

  always_comb begin
    flim[F_SEC]  = 8'h59;
    flim[F_MIN]  = 8'h59;
    flim[F_HOUR] = 8'h23;
    flim[F_WDAY] = 8'h07;
    flim[F_MDAY] = feb_last;
    flim[F_MON]  = 8'h12;
    flim[F_YEAR] = 8'h99;
  end

  rtc_month_days u_mdays (
    .mon      (fq[F_MON]),
    .year     (fq[F_YEAR]),
    .last_day (feb_last)
  );

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    assign fld[i] = wr_en && (wr_sel == SEL_W'(i));
    rtc_bcd_field #(
      .RST_VAL (RST_TAB[i]),
      .MIN_VAL (MIN_TAB[i])
    ) u_fld (
      .clk     (clk),
      .rst     (rst),
      .inc     (finc[i]),
      .ld      (fld[i]),
      .ld_data (wr_data),
      .lim     (flim[i]),
      .q       (fq[i]),
      .at_lim  (fat[i])
    );
  end

  assign sec_o  = fq[F_SEC];
  assign min_o  = fq[F_MIN];
  assign hour_o = fq[F_HOUR];
  assign wday_o = fq[F_WDAY];
  assign mday_o = fq[F_MDAY];
  assign mon_o  = fq[F_MON];
  assign year_o = fq[F_YEAR];

  // R8: hold with no write leaves every field untouched
  a_r8_hold_freeze: assert property (@(posedge clk) disable iff (rst)
    (hold && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                          $stable(mday_o) && $stable(mon_o) && $stable(year_o) &&
                          $stable(wday_o)));
  // R9: a second write lands verbatim
  a_r9_load_sec: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 3'd0) |=> (sec_o == $past(wr_data)));
  // R10: a write in the tick cycle keeps the seconds from moving
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tick && wr_sel != 3'd0) |=> $stable(sec_o));
  // R4: weekday wraps back to Sunday
  a_r4_wday_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23 && wday_o == 8'h07)
      |=> (wday_o == 8'h01));
  // R7: year rolls from 99 to 00 at the very end of December
  a_r7_year_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23 &&
     mday_o == 8'h31 && mon_o == 8'h12 && year_o == 8'h99) |=> (year_o == 8'h00));
  // R6: day 29 of February is always the last day it can reach
  a_r6_feb_end: assert property (@(posedge clk) disable iff (rst)
    (step && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23 &&
     mday_o == 8'h29 && mon_o == 8'h02) |=> (mday_o == 8'h01 && mon_o == 8'h03));
endmodule

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
  logic clk = 1'b0;
  logic rst, tick, hold, wr_en;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_calendar_core u0 (
    .clk(clk), .rst(rst), .tick(tick), .hold(hold), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o),
    .year_o(year_o)
  );

  // packing: year, month, day, weekday, hour, minute, second
  localparam int NV = 17;
  localparam logic [111:0] VEC [NV] = '{
    {56'h24_03_15_03_10_20_08, 56'h24_03_15_03_10_20_09}, // R2 plain step
    {56'h24_03_15_03_10_20_09, 56'h24_03_15_03_10_20_10}, // R2 digit carry
    {56'h24_03_15_03_10_20_59, 56'h24_03_15_03_10_21_00}, // R2 second wrap
    {56'h24_03_15_03_10_59_59, 56'h24_03_15_03_11_00_00}, // R2 minute wrap
    {56'h24_03_15_03_23_59_59, 56'h24_03_16_04_00_00_00}, // R3 day advance
    {56'h24_03_15_07_23_59_59, 56'h24_03_16_01_00_00_00}, // R4 weekday wrap
    {56'h24_04_30_02_23_59_59, 56'h24_05_01_03_00_00_00}, // R5 30-day month
    {56'h24_01_31_02_23_59_59, 56'h24_02_01_03_00_00_00}, // R5 31-day month
    {56'h24_09_30_02_23_59_59, 56'h24_10_01_03_00_00_00}, // R5 September
    {56'h24_10_30_02_23_59_59, 56'h24_10_31_03_00_00_00}, // R5 October 30th
    {56'h23_02_28_02_23_59_59, 56'h23_03_01_03_00_00_00}, // R6 common year
    {56'h24_02_28_02_23_59_59, 56'h24_02_29_03_00_00_00}, // R6 leap day
    {56'h24_02_29_02_23_59_59, 56'h24_03_01_03_00_00_00}, // R6 after leap day
    {56'h00_02_28_02_23_59_59, 56'h00_02_29_03_00_00_00}, // R6 year 2000
    {56'h50_02_28_02_23_59_59, 56'h50_03_01_03_00_00_00}, // R6 year 1950
    {56'h96_02_28_02_23_59_59, 56'h96_02_29_03_00_00_00}, // R6 year 1996
    {56'h99_12_31_05_23_59_59, 56'h00_01_01_06_00_00_00}  // R7 year wrap
  };

  function automatic logic [55:0] now();
    return {year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o};
  endfunction

  task automatic check(input string tag, input logic [55:0] got, input logic [55:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all(input logic [55:0] v);
    for (int f = 0; f < 7; f++) wr(3'(f), v[f*8 +: 8]);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    rst = 1'b1; tick = 1'b0; hold = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset", now(), 56'h00_01_01_07_00_00_00);

    for (int i = 0; i < NV; i++) begin
      load_all(VEC[i][111:56]);
      pulse_tick();
      check($sformatf("vector %0d", i), now(), VEC[i][55:0]);
    end

    // R8: hold drops ticks
    load_all(56'h24_06_10_02_12_30_45);
    hold = 1'b1;
    pulse_tick();
    pulse_tick();
    check("R8 hold", now(), 56'h24_06_10_02_12_30_45);
    // R9: write accepted during hold
    wr(3'd2, 8'h07);
    check("R9 write in hold", now(), 56'h24_06_10_02_07_30_45);
    hold = 1'b0;
    // R9: select 7 writes nothing
    wr(3'd7, 8'h55);
    check("R9 select 7", now(), 56'h24_06_10_02_07_30_45);
    // R10: write and tick in one cycle
    wr(3'd0, 8'h05);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h33;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    check("R10 write wins", now(), 56'h24_06_10_02_07_33_05);
    pulse_tick();
    check("R10 next tick counts", now(), 56'h24_06_10_02_07_33_06);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule